// File: doc/BRIEF.md
# Fractional Control Word Modulator with Delay Code Output

This block converts a frequency control word into a whole-number reference code once per retimed clock cycle. The word has an integer part and a 16-bit fractional part. A first-order error-feedback accumulator adds the fractional part every enabled cycle. Its carry out is a dither bit of 0 or 1, which is added to the integer part. The reference code therefore only ever takes integer values, and its long-run mean equals the full control word.

The residue left in the accumulator is the quantization error of that cycle. The block outputs it directly, together with a polarity flag taken relative to half an integer step. It also multiplies the residue by a calibrated gain to form an unsigned delay code for a digital-to-time converter. With a correct gain, that delay shifts the reference edge onto the same oscillator edge that the modulator selected. A gain that is too small or too large shifts the edge too little or too far. When the enable is low, the dither is forced to zero, the delay code is zero and the accumulator is cleared.

Top module: `fcw_dsm_dtc`

## Requirements
- R1: While reset is asserted, all four outputs are zero: ref_code, qe, qe_neg and dtc_code.
- R2: In an enabled cycle, ref_code becomes fcw_int plus the accumulator carry (0 or 1) on the next rising edge. The carry is set when the old residue plus fcw_frac reaches 2^16.
- R3: Starting from a cleared accumulator, the number of cycles in which ref_code equals fcw_int+1 over N enabled cycles with a constant fcw_frac is floor(N·fcw_frac/2^16). For N=64 and fcw_frac=0x6000 that is 24.
- R4: qe shows the 16-bit accumulator residue after the update: (old residue + fcw_frac) mod 2^16.
- R5: qe_neg is 1 when the block is enabled and qe is below 0x8000 (bit 15 of qe clear). Otherwise it is 0.
- R6: dtc_code equals (qe × dtc_gain) >> 16, computed from the same cycle's residue and registered together with qe.
- R7: When (qe × dtc_gain) >> 16 exceeds 1023, dtc_code saturates at 1023.
- R8: In a disabled cycle, the next edge gives ref_code = fcw_int, qe = 0, qe_neg = 0 and dtc_code = 0, and the accumulator clears. After re-enabling, the dither sequence restarts from a zero residue.
- R9: With fcw_frac = 0 and a cleared accumulator, ref_code stays equal to fcw_int and qe stays 0.
- R10: ref_code is one bit wider than fcw_int. With fcw_int = 255, a carry gives ref_code = 256 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retimed clock; one modulator update per rising edge |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Modulator enable; low clears the accumulator and zeroes the dither |
| fcw_int | input | 8 | Integer part of the control word |
| fcw_frac | input | 16 | Fractional part of the control word, in units of 2^-16 |
| dtc_gain | input | 12 | Calibrated delay gain applied to the residue |
| ref_code | output | 9 | Integer reference code, fcw_int plus dither |
| qe | output | 16 | Quantization residue of the current cycle |
| qe_neg | output | 1 | Residue polarity: below half an integer step |
| dtc_code | output | 10 | Gain-scaled, saturated delay code |

## Verification
The properties assume that every input is stable across the sampling edge and changes only between edges. They also assume that en stays low until the internal reset has been released for a few cycles. Under those assumptions, each registered output is a pure function of the inputs at the previous edge and of the residue shown on qe. The stimulus changes inputs only on falling clock edges and holds en low through the reset release and for several cycles after it. It then covers:
- dither patterns with several fractional values,
- integer parts near the top of the range,
- gains that push the scaled residue both below and above the saturation limit,
- disable periods placed in the middle of a dither sequence.

// File: rtl/fcw_dsm_pkg.sv
`timescale 1ns/1ps
package fcw_dsm_pkg;
  // Default widths shared by the modulator, its scaler and its checker
  localparam int unsigned DEF_INT_W  = 8;
  localparam int unsigned DEF_FRAC_W = 16;
  localparam int unsigned DEF_GAIN_W = 12;
  localparam int unsigned DEF_DTC_W  = 10;
endpackage

// File: rtl/fcw_rst_sync.sv
`timescale 1ns/1ps
module fcw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign rst_n = stg_q[STAGES-1];
endmodule

// File: rtl/fcw_frac_accum.sv
`timescale 1ns/1ps
module fcw_frac_accum #(
  parameter int unsigned FRAC_W = fcw_dsm_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry,
  output logic [FRAC_W-1:0] residue
);
  localparam int unsigned SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_d;
  logic [SUM_W-1:0]  sum;

  // Next state: error-feedback add, residue kept, carry is the dither bit
  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, frac};
    carry   = en & sum[FRAC_W];
    residue = en ? sum[FRAC_W-1:0] : '0;
    acc_d   = residue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/fcw_dtc_scale.sv
`timescale 1ns/1ps
module fcw_dtc_scale #(
  parameter int unsigned FRAC_W = fcw_dsm_pkg::DEF_FRAC_W,
  parameter int unsigned GAIN_W = fcw_dsm_pkg::DEF_GAIN_W,
  parameter int unsigned DTC_W  = fcw_dsm_pkg::DEF_DTC_W
) (
  input  logic [FRAC_W-1:0] residue,
  input  logic [GAIN_W-1:0] gain,
  output logic [DTC_W-1:0]  code
);
  localparam int unsigned PROD_W = FRAC_W + GAIN_W;

  logic [PROD_W-1:0] prod;
  logic [GAIN_W-1:0] scaled;

  always_comb begin
    prod   = PROD_W'(residue) * PROD_W'(gain);
    scaled = prod[PROD_W-1:FRAC_W];
  end

  generate
    if (GAIN_W > DTC_W) begin : g_sat
      // Scaled value can exceed the code range: clamp to all ones
      assign code = (|scaled[GAIN_W-1:DTC_W]) ? '1 : scaled[DTC_W-1:0];
    end else begin : g_ext
      assign code = DTC_W'(scaled);
    end
  endgenerate
endmodule

// File: rtl/fcw_dsm_dtc.sv
`timescale 1ns/1ps
module fcw_dsm_dtc #(
  parameter int unsigned INT_W  = fcw_dsm_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = fcw_dsm_pkg::DEF_FRAC_W,
  parameter int unsigned GAIN_W = fcw_dsm_pkg::DEF_GAIN_W,
  parameter int unsigned DTC_W  = fcw_dsm_pkg::DEF_DTC_W
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  fcw_int,
  input  logic [FRAC_W-1:0] fcw_frac,
  input  logic [GAIN_W-1:0] dtc_gain,
  output logic [INT_W:0]    ref_code,
  output logic [FRAC_W-1:0] qe,
  output logic              qe_neg,
  output logic [DTC_W-1:0]  dtc_code
);
  localparam int unsigned REF_W = INT_W + 1;

  logic              rst_sync_n;
  logic              carry;
  logic [FRAC_W-1:0] residue;
  logic [DTC_W-1:0]  code;

  logic [REF_W-1:0]  ref_d;
  logic [FRAC_W-1:0] qe_d;
  logic              neg_d;
  logic [DTC_W-1:0]  dtc_d;

  fcw_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_sync_n)
  );

  fcw_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (en),
    .frac    (fcw_frac),
    .carry   (carry),
    .residue (residue)
  );

  fcw_dtc_scale #(.FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .DTC_W(DTC_W)) u_scale (
    .residue (residue),
    .gain    (dtc_gain),
    .code    (code)
  );

  // Next-state of the output stage
  always_comb begin
    ref_d = REF_W'(fcw_int) + REF_W'(carry);
    qe_d  = residue;
    neg_d = en & ~residue[FRAC_W-1];
    dtc_d = en ? code : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ref_code <= '0;
      qe       <= '0;
      qe_neg   <= 1'b0;
      dtc_code <= '0;
    end else begin
      ref_code <= ref_d;
      qe       <= qe_d;
      qe_neg   <= neg_d;
      dtc_code <= dtc_d;
    end
  end
endmodule

// File: rtl/fcw_dsm_dtc_chk.sv
`timescale 1ns/1ps
module fcw_dsm_dtc_chk #(
  parameter int unsigned INT_W  = fcw_dsm_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = fcw_dsm_pkg::DEF_FRAC_W,
  parameter int unsigned DTC_W  = fcw_dsm_pkg::DEF_DTC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [INT_W-1:0]  fcw_int,
  input logic [FRAC_W-1:0] fcw_frac,
  input logic [INT_W:0]    ref_code,
  input logic [FRAC_W-1:0] qe,
  input logic              qe_neg,
  input logic [DTC_W-1:0]  dtc_code
);
  localparam int unsigned REF_W = INT_W + 1;
  localparam int unsigned SUM_W = REF_W + FRAC_W;
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  // R2, R10: the code never moves below the integer part or more than one above
  a_r2_ref_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ref_code >= REF_W'($past(fcw_int))) &&
           (ref_code <= REF_W'($past(fcw_int)) + REF_W'(1)));

  // R4: the dither bit and the residue together preserve the accumulated sum
  a_r4_residue_chain: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((SUM_W'(ref_code - REF_W'($past(fcw_int))) << FRAC_W) + SUM_W'(qe)) ==
           (SUM_W'($past(qe)) + SUM_W'($past(fcw_frac))));

  // R8: a disabled cycle gives a plain integer code and zero error and delay
  a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ref_code == REF_W'($past(fcw_int))) && (qe == '0) &&
            !qe_neg && (dtc_code == '0));

  // R5: the polarity flag only appears with a residue below half a step
  a_r5_sign_half: assert property (@(posedge clk) disable iff (!rst_n)
    qe_neg |-> (qe < HALF));

  // R6: a zero residue yields zero delay
  a_r6_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (qe == '0) |-> (dtc_code == '0));

  // R9: zero fraction on a zero residue gives no dither
  a_r9_no_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (fcw_frac == '0) && (qe == '0)) |=>
      (ref_code == REF_W'($past(fcw_int))) && (qe == '0));
endmodule

bind fcw_dsm_dtc fcw_dsm_dtc_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .DTC_W(DTC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en       (en),
  .fcw_int  (fcw_int),
  .fcw_frac (fcw_frac),
  .ref_code (ref_code),
  .qe       (qe),
  .qe_neg   (qe_neg),
  .dtc_code (dtc_code)
);

// File: tb/tb_fcw_dsm_dtc.sv
`timescale 1ns/1ps
module tb_fcw_dsm_dtc;
  logic        clk;
  logic        arst_n;
  logic        en;
  logic [7:0]  fcw_int;
  logic [15:0] fcw_frac;
  logic [11:0] dtc_gain;
  logic [8:0]  ref_code;
  logic [15:0] qe;
  logic        qe_neg;
  logic [9:0]  dtc_code;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [8:0]  ref_v;
    logic [15:0] qe_v;
    logic        neg_v;
    logic [9:0]  dtc_v;
    logic [7:0]  int_v;
    bit          count;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] m_acc;
  int          obs_carries;

  fcw_dsm_dtc dut (
    .clk(clk), .arst_n(arst_n), .en(en), .fcw_int(fcw_int),
    .fcw_frac(fcw_frac), .dtc_gain(dtc_gain), .ref_code(ref_code),
    .qe(qe), .qe_neg(qe_neg), .dtc_code(dtc_code)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result
  task automatic drive(input bit e, input int iv, input int fv, input int gv,
                       input string tag, input bit count = 0);
    exp_t   x;
    longint sum;
    longint sc;
    @(negedge clk);
    en = e; fcw_int = 8'(iv); fcw_frac = 16'(fv); dtc_gain = 12'(gv);
    if (e) begin
      sum     = longint'(m_acc) + longint'(fv);
      m_acc   = 16'(sum);
      x.ref_v = 9'(iv + int'(sum >> 16));
      x.qe_v  = m_acc;
      x.neg_v = (m_acc < 16'h8000);
      sc      = (longint'(m_acc) * longint'(gv)) >> 16;
      x.dtc_v = (sc > 1023) ? 10'd1023 : 10'(sc);
    end else begin
      m_acc   = '0;
      x.ref_v = 9'(iv);
      x.qe_v  = '0;
      x.neg_v = 1'b0;
      x.dtc_v = '0;
    end
    x.int_v = 8'(iv);
    x.count = count;
    x.tag   = tag;
    sb.push_back(x);
  endtask

  // Monitor: compare just after each edge against the queued expectation
  always begin
    exp_t y;
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      y = sb.pop_front();
      check({y.tag, " ref_code"}, ref_code, y.ref_v);
      check("R4 qe", qe, y.qe_v);
      check("R5 qe_neg", qe_neg, y.neg_v);
      check((y.tag == "R7") ? "R7 dtc_code" : "R6 dtc_code", dtc_code, y.dtc_v);
      if (y.count && (ref_code == 9'(y.int_v) + 9'd1)) obs_carries++;
    end
  end

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_acc = '0; obs_carries = 0;
    arst_n = 1'b0; en = 1'b0; fcw_int = 8'd5; fcw_frac = 16'h1234; dtc_gain = 12'd100;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ref_code", ref_code, 0);
    check("R1 qe", qe, 0);
    check("R1 qe_neg", qe_neg, 0);
    check("R1 dtc_code", dtc_code, 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: disabled cycles
    for (int i = 0; i < 3; i++) drive(0, 5, 16'h1234, 100, "R8");
    // R2: quarter fraction, dither every fourth cycle
    for (int i = 0; i < 8; i++) drive(1, 20, 16'h4000, 1024, "R2");
    // R8: disable mid-sequence, then restart from zero residue
    drive(0, 20, 16'h4000, 1024, "R8");
    for (int i = 0; i < 5; i++) drive(1, 20, 16'h4000, 1024, "R8");

    // R3: long-run mean over 64 cycles from a cleared accumulator
    drive(0, 40, 16'h6000, 2048, "R8");
    drain();
    obs_carries = 0;
    for (int i = 0; i < 64; i++) drive(1, 40, 16'h6000, 2048, "R3", 1);
    drain();
    check("R3 carry count", obs_carries, 24);

    // R6: varied gains with an irregular fraction
    drive(0, 12, 16'h1234, 3000, "R8");
    for (int i = 0; i < 10; i++) drive(1, 12, 16'h1234, 300 + 350 * i, "R6");

    // R7: large residue with full gain saturates
    drive(0, 3, 16'hFFFF, 4095, "R8");
    for (int i = 0; i < 6; i++) drive(1, 3, 16'hFFFF, 4095, "R7");

    // R10: top integer value with carry
    drive(0, 255, 16'h8000, 512, "R8");
    for (int i = 0; i < 6; i++) drive(1, 255, 16'h8000, 512, "R10");

    // R9: zero fraction after clearing
    drive(0, 77, 16'h0000, 4000, "R8");
    for (int i = 0; i < 6; i++) drive(1, 77, 16'h0000, 4000, "R9");

    drive(0, 0, 0, 0, "R8");
    drain();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule